// File: doc/BRIEF.md
# ADC Conversion Result Buffer

This block sits between a conversion sequencer and a read port shared by a CPU and a DMA engine. Each incoming conversion result is a left-aligned unsigned code. At write time the block can turn it into two's complement form, and then it stores it in one of three modes, chosen by two configuration inputs.

In indexed mode, the result goes into one of four result registers, selected by the index of the control entry that produced it. Each register has a valid bit. In queued mode, results wait in a first-in first-out store and are read one per access in the low half of the read word. In packed mode, the same store hands out two results per 32-bit read. The block asks for DMA service whenever a read would succeed. It pulses an event when a DMA transfer of a fixed number of reads has completed, and it pulses overflow and underflow events when a write or a read cannot be honoured.

The mode controller is a three-state machine: `S_INDEXED`, `S_QUEUED` and `S_PACKED`. Each cycle the next state follows the configuration inputs: `fifo_mode`=0 gives `S_INDEXED`, `fifo_mode`=1 with `pack_en`=0 gives `S_QUEUED`, and `fifo_mode`=1 with `pack_en`=1 gives `S_PACKED`. Any transition between two different states is a flush transition, and any same-state transition is a hold transition. The queue depth must be a power of two, at least 2.

Top module: `adc_rbuf`

## Requirements
- R1: In indexed mode, a write (`res_valid`=1) stores the formatted result in register `res_idx` and sets bit `res_idx` of `valid_mask`. Writing a register that is already valid overwrites it and raises no event.
- R2: In indexed mode, `rd_data` is zero in bits 31:16 and holds register `rd_idx` in bits 15:0. A read (`cpu_rd` or `dma_rd`) clears bit `rd_idx` of `valid_mask`. A write to the same index in the same cycle leaves that bit set with the new data.
- R3: In queued mode, results leave in arrival order. `rd_data` shows the oldest result in bits 15:0, with zero in bits 31:16. `rd_data` is all zero when the queue is empty. `fifo_level` gives the number of stored results and is zero in indexed mode.
- R4: In packed mode, `rd_data` holds the older result in bits 15:0 and the next one in bits 31:16 whenever at least two results are stored, and is zero otherwise. A read removes both results.
- R5: With `twos_fmt`=1 at write time, bit 15 of the code is inverted before storage. With `twos_fmt`=0, the code is stored as given.
- R6: A write in a queue mode while `fifo_level` equals the depth is dropped, and `ovf_evt` is 1 in the following cycle only.
- R7: A read in a queue mode with fewer results stored than one read takes (1 in queued, 2 in packed) removes nothing, and `unf_evt` is 1 in the following cycle only. A write in the same cycle is still accepted.
- R8: `data_ready` and `dma_req` are 1 in indexed mode when any valid bit is set, in queued mode when at least one result is stored, and in packed mode when at least two are stored.
- R9: Every successful DMA read advances a transfer count: in indexed mode a read of a valid register, in a queue mode a read that removes data. The read that completes `XFER_WORDS` of them makes `dma_done` 1 for the following cycle, and the count restarts.
- R10: In a cycle where the configuration selects a different mode, the clock edge clears every register, valid bit, queued result and the transfer count. Writes and reads in that cycle are ignored.
- R11: After reset the block is in indexed mode, with all outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects a queue mode |
| pack_en | input | 1 | 1 packs two results per read in queue mode |
| twos_fmt | input | 1 | 1 stores results in two's complement form |
| res_valid | input | 1 | Result write strobe |
| res_idx | input | IDX_W (2) | Control-entry index of the result |
| res_code | input | RES_W (16) | Left-aligned unsigned conversion code |
| cpu_rd | input | 1 | CPU read strobe |
| dma_rd | input | 1 | DMA read strobe |
| rd_idx | input | IDX_W (2) | Register selected for indexed reads |
| rd_data | output | 2*RES_W (32) | Read word |
| data_ready | output | 1 | A read would succeed |
| dma_req | output | 1 | DMA service request |
| valid_mask | output | NUM_REGS (4) | Per-register valid bits |
| fifo_level | output | LVL_W (4) | Results stored in the queue |
| ovf_evt | output | 1 | Dropped-write pulse |
| unf_evt | output | 1 | Empty-read pulse |
| dma_done | output | 1 | DMA transfer complete pulse |

## Verification
The hardest case to reach is the boundary where the queue is full and a write and a read arrive in the same cycle. Close to it is packed mode holding exactly one result when a read and a write coincide. There the read must underflow and the write must still land. The stimulus gets there with directed runs that overfill the queue and then drain it to a single entry. A long randomised phase follows, with write and read rates skewed per segment and occasional mode flips that fall in cycles carrying traffic. A behavioural queue model is compared with every output on every clock.

// File: rtl/adc_rbuf_pkg.sv
package adc_rbuf_pkg;
    typedef enum logic [1:0] {
        S_INDEXED = 2'd0,
        S_QUEUED  = 2'd1,
        S_PACKED  = 2'd2
    } rbuf_state_t;
endpackage

// File: rtl/adc_rbuf_fmt.sv
module adc_rbuf_fmt #(
    parameter int W = 16
) (
    input  logic         twos,
    input  logic [W-1:0] code,
    output logic [W-1:0] word
);
    // Offset binary to two's complement: flip the sign position only.
    always_comb begin
        word = code;
        if (twos) word[W-1] = ~code[W-1];
    end
endmodule

// File: rtl/adc_rbuf_regs.sv
module adc_rbuf_regs #(
    parameter int W     = 16,
    parameter int NREG  = 4,
    localparam int IW   = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            wr,
    input  logic [IW-1:0]   wr_idx,
    input  logic [W-1:0]    din,
    input  logic            rd,
    input  logic [IW-1:0]   rd_idx,
    output logic [W-1:0]    rd_word,
    output logic [NREG-1:0] vld
);
    logic [W-1:0] regs_q [NREG];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs_q[g] <= '0;
                    vld[g]    <= 1'b0;
                end else if (flush) begin
                    regs_q[g] <= '0;
                    vld[g]    <= 1'b0;
                end else if (wr && wr_idx == IW'(g)) begin
                    regs_q[g] <= din;
                    vld[g]    <= 1'b1;
                end else if (rd && rd_idx == IW'(g)) begin
                    vld[g]    <= 1'b0;
                end
            end
        end
    endgenerate

    assign rd_word = regs_q[rd_idx];
endmodule

// File: rtl/adc_rbuf_fifo.sv
module adc_rbuf_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic [1:0]    pop_cnt,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [PW-1:0] rptr_nx;

    assign rptr_nx = rptr_q + PW'(1);
    assign head0   = mem_q[rptr_q];
    assign head1   = mem_q[rptr_nx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            level  <= '0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            level  <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + PW'(1);
            rptr_q <= rptr_q + PW'(pop_cnt);
            level  <= level + LW'(push) - LW'(pop_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[wptr_q] <= din;
    end
endmodule

// File: rtl/adc_rbuf.sv
module adc_rbuf
    import adc_rbuf_pkg::*;
#(
    parameter int RES_W      = 16,
    parameter int NUM_REGS   = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int XFER_WORDS = 4,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int XCNT_W    = $clog2(XFER_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_mode,
    input  logic                pack_en,
    input  logic                twos_fmt,
    input  logic                res_valid,
    input  logic [IDX_W-1:0]    res_idx,
    input  logic [RES_W-1:0]    res_code,
    input  logic                cpu_rd,
    input  logic                dma_rd,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [2*RES_W-1:0]  rd_data,
    output logic                data_ready,
    output logic                dma_req,
    output logic [NUM_REGS-1:0] valid_mask,
    output logic [LVL_W-1:0]    fifo_level,
    output logic                ovf_evt,
    output logic                unf_evt,
    output logic                dma_done
);
    rbuf_state_t state_q, state_d;
    logic              mode_chg, rd_any;
    logic [RES_W-1:0]  fmt_word, reg_word, head0, head1;
    logic              reg_wr, reg_rd, fifo_push, rd_ok, ovf_d, unf_d;
    logic [1:0]        pop_cnt, need;
    logic              enough, full;
    logic [XCNT_W-1:0] xcnt_q;

    // Next state comes straight from configuration.
    always_comb begin
        state_d = S_INDEXED;
        if (fifo_mode) state_d = pack_en ? S_PACKED : S_QUEUED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_INDEXED;
        else        state_q <= state_d;
    end

    assign mode_chg = (state_d != state_q);
    assign rd_any   = cpu_rd | dma_rd;
    assign full     = (fifo_level == LVL_W'(FIFO_DEPTH));

    adc_rbuf_fmt #(.W(RES_W)) fmt_i (
        .twos(twos_fmt), .code(res_code), .word(fmt_word)
    );

    adc_rbuf_regs #(.W(RES_W), .NREG(NUM_REGS)) regs_i (
        .clk(clk), .rst_n(rst_n), .flush(mode_chg),
        .wr(reg_wr), .wr_idx(res_idx), .din(fmt_word),
        .rd(reg_rd), .rd_idx(rd_idx),
        .rd_word(reg_word), .vld(valid_mask)
    );

    adc_rbuf_fifo #(.W(RES_W), .DEPTH(FIFO_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .flush(mode_chg),
        .push(fifo_push), .din(fmt_word), .pop_cnt(pop_cnt),
        .head0(head0), .head1(head1), .level(fifo_level)
    );

    // Per-state output and strobe decoding.
    always_comb begin
        rd_data    = '0;
        data_ready = 1'b0;
        reg_wr     = 1'b0;
        reg_rd     = 1'b0;
        fifo_push  = 1'b0;
        pop_cnt    = 2'd0;
        ovf_d      = 1'b0;
        unf_d      = 1'b0;
        rd_ok      = 1'b0;
        need       = (state_q == S_PACKED) ? 2'd2 : 2'd1;
        enough     = (fifo_level >= LVL_W'(need));
        unique case (state_q)
            S_INDEXED: begin
                rd_data    = {{RES_W{1'b0}}, reg_word};
                data_ready = |valid_mask;
                reg_wr     = res_valid && !mode_chg;
                reg_rd     = rd_any && !mode_chg;
                rd_ok      = valid_mask[rd_idx];
            end
            S_QUEUED, S_PACKED: begin
                if (enough)
                    rd_data = (state_q == S_PACKED) ? {head1, head0}
                                                    : {{RES_W{1'b0}}, head0};
                data_ready = enough;
                fifo_push  = res_valid && !mode_chg && !full;
                ovf_d      = res_valid && !mode_chg && full;
                unf_d      = rd_any && !mode_chg && !enough;
                rd_ok      = enough;
                if (rd_any && !mode_chg && enough) pop_cnt = need;
            end
            default: ;
        endcase
    end

    assign dma_req = data_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_evt  <= 1'b0;
            unf_evt  <= 1'b0;
            dma_done <= 1'b0;
            xcnt_q   <= '0;
        end else begin
            ovf_evt  <= ovf_d;
            unf_evt  <= unf_d;
            dma_done <= 1'b0;
            if (mode_chg) begin
                xcnt_q <= '0;
            end else if (dma_rd && rd_ok) begin
                if (xcnt_q == XCNT_W'(XFER_WORDS - 1)) begin
                    xcnt_q   <= '0;
                    dma_done <= 1'b1;
                end else begin
                    xcnt_q <= xcnt_q + XCNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_rbuf_chk.sv
module adc_rbuf_chk #(
    parameter int NUM_REGS   = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int XFER_WORDS = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                res_valid,
    input logic                cpu_rd,
    input logic                dma_rd,
    input logic [NUM_REGS-1:0] valid_mask,
    input logic [LVL_W-1:0]    fifo_level,
    input logic                ovf_evt,
    input logic                unf_evt,
    input logic                dma_done
);
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= FIFO_DEPTH); // R6

    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> $past(res_valid) && int'($past(fifo_level)) == FIFO_DEPTH); // R6

    AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |-> $past(cpu_rd) || $past(dma_rd)); // R7

    AST_EVT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_evt && unf_evt)); // R7

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        int'(fifo_level) <= int'($past(fifo_level)) + 1); // R3

    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |-> $past(dma_rd)); // R9

    AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_done && XFER_WORDS > 1) |=> !dma_done); // R9

    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_mask != '0) |-> (fifo_level == '0)); // R10
endmodule

bind adc_rbuf adc_rbuf_chk #(
    .NUM_REGS(NUM_REGS), .FIFO_DEPTH(FIFO_DEPTH), .XFER_WORDS(XFER_WORDS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .cpu_rd(cpu_rd),
    .dma_rd(dma_rd), .valid_mask(valid_mask), .fifo_level(fifo_level),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt), .dma_done(dma_done)
);

// File: tb/adc_rbuf_tb_top.sv
module adc_rbuf_tb_top;
    localparam int DEPTH = 8;
    localparam int XFER  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_mode = 0, pack_en = 0, twos_fmt = 0;
    logic        res_valid = 0, cpu_rd = 0, dma_rd = 0;
    logic [1:0]  res_idx = 0, rd_idx = 0;
    logic [15:0] res_code = 0;
    logic [31:0] rd_data;
    logic        data_ready, dma_req, ovf_evt, unf_evt, dma_done;
    logic [3:0]  valid_mask;
    logic [3:0]  fifo_level;

    int compared = 0, mismatched = 0, cycles = 0;
    bit finished = 0;

    // Behavioural reference state.
    int          m_mode = 0;
    int          m_q[$];
    logic [15:0] m_reg[4];
    logic [3:0]  m_vld = 0;
    bit          m_ovf = 0, m_unf = 0, m_done = 0;
    int          m_dcnt = 0;

    always #4 clk = ~clk;

    adc_rbuf #(.FIFO_DEPTH(DEPTH), .XFER_WORDS(XFER)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .pack_en(pack_en),
        .twos_fmt(twos_fmt), .res_valid(res_valid), .res_idx(res_idx),
        .res_code(res_code), .cpu_rd(cpu_rd), .dma_rd(dma_rd), .rd_idx(rd_idx),
        .rd_data(rd_data), .data_ready(data_ready), .dma_req(dma_req),
        .valid_mask(valid_mask), .fifo_level(fifo_level), .ovf_evt(ovf_evt),
        .unf_evt(unf_evt), .dma_done(dma_done)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e_data;
        bit          e_rdy;
        e_data = 0;
        e_rdy  = 0;
        if (m_mode == 0) begin
            e_data = {16'h0, m_reg[rd_idx]};
            e_rdy  = (m_vld != 0);
        end else if (m_mode == 1) begin
            if (m_q.size() >= 1) begin e_data = {16'h0, 16'(m_q[0])}; e_rdy = 1; end
        end else begin
            if (m_q.size() >= 2) begin e_data = {16'(m_q[1]), 16'(m_q[0])}; e_rdy = 1; end
        end
        chk(m_mode == 0 ? "R2" : (m_mode == 1 ? "R3" : "R4"), "rd_data", rd_data, e_data);
        chk("R8", "data_ready", {31'h0, data_ready}, {31'h0, e_rdy});
        chk("R8", "dma_req", {31'h0, dma_req}, {31'h0, e_rdy});
        chk("R1", "valid_mask", {28'h0, valid_mask}, {28'h0, m_vld});
        chk("R3", "fifo_level", {28'h0, fifo_level}, 32'(m_q.size()));
        chk("R6", "ovf_evt", {31'h0, ovf_evt}, {31'h0, m_ovf});
        chk("R7", "unf_evt", {31'h0, unf_evt}, {31'h0, m_unf});
        chk("R9", "dma_done", {31'h0, dma_done}, {31'h0, m_done});
    endtask

    // Apply one cycle of stimulus, advance the model at the edge, compare after.
    task automatic step(bit fm, bit pk, bit tw, bit wv, logic [1:0] wi,
                        logic [15:0] code, bit cr, bit dr, logic [1:0] ri);
        int nmode, need;
        bit ok;
        logic [15:0] fw;
        fifo_mode = fm; pack_en = pk; twos_fmt = tw; res_valid = wv;
        res_idx = wi; res_code = code; cpu_rd = cr; dma_rd = dr; rd_idx = ri;
        @(posedge clk);
        nmode  = fm ? (pk ? 2 : 1) : 0;
        m_ovf  = 0; m_unf = 0; m_done = 0; ok = 0;
        fw     = tw ? (code ^ 16'h8000) : code;   // R5
        if (nmode != m_mode) begin               // R10
            m_mode = nmode;
            m_q.delete();
            m_vld  = 0;
            m_dcnt = 0;
            for (int i = 0; i < 4; i++) m_reg[i] = 0;
        end else begin
            if (m_mode == 0) begin
                if (cr || dr) begin ok = m_vld[ri]; m_vld[ri] = 0; end
                if (wv) begin m_reg[wi] = fw; m_vld[wi] = 1; end
            end else begin
                need = (m_mode == 2) ? 2 : 1;
                if (cr || dr) begin
                    if (m_q.size() >= need) begin
                        ok = 1;
                        for (int k = 0; k < need; k++) void'(m_q.pop_front());
                    end else m_unf = 1;
                end
                if (wv) begin
                    if (m_q.size() + (ok ? need : 0) < DEPTH) m_q.push_back(int'(fw));
                    else m_ovf = 1;
                end
            end
            if (dr && ok) begin
                if (m_dcnt == XFER - 1) begin m_done = 1; m_dcnt = 0; end
                else m_dcnt++;
            end
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_reg[i] = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "rd_data", rd_data, 32'h0);
        chk("R11", "valid_mask", {28'h0, valid_mask}, 32'h0);
        chk("R11", "events", {29'h0, ovf_evt, unf_evt, dma_done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R5: indexed writes, overwrite, reads, write-wins
        step(0,0,0,1,2'd0,16'h1230,0,0,2'd0);
        step(0,0,1,1,2'd3,16'h0FF0,0,0,2'd3);
        step(0,0,0,1,2'd3,16'hA5A0,0,0,2'd3);
        step(0,0,0,0,2'd0,16'h0,1,0,2'd3);
        step(0,0,0,1,2'd0,16'h7770,0,1,2'd0);
        step(0,0,0,0,2'd0,16'h0,0,1,2'd0);
        step(0,0,0,0,2'd0,16'h0,0,1,2'd2);

        // R3, R6: queue overfill then drain past empty (R7)
        step(1,0,0,0,0,0,0,0,0);
        for (int i = 0; i < DEPTH + 2; i++) step(1,0,i[0],1,0,16'(16'h1000 + i*16'h0110),0,0,0);
        step(1,0,0,1,0,16'hBEEF,1,0,0);
        for (int i = 0; i < DEPTH + 1; i++) step(1,0,0,0,0,0,0,1,0);

        // R4, R7: packed mode, single entry underflow with write in same cycle, R9
        step(1,1,0,1,0,16'h1111,0,0,0);
        step(1,1,0,1,0,16'h2222,0,0,0);
        step(1,1,0,1,0,16'h3333,1,0,0);
        step(1,1,0,1,0,16'h4444,1,0,0);
        for (int i = 0; i < 10; i++) step(1,1,0,1,0,16'(i*16'h0101),0,1,0);
        for (int i = 0; i < 6; i++) step(1,1,0,0,0,0,0,1,0);

        // R10: mode flip in a cycle with traffic
        step(1,1,0,1,0,16'h5555,0,0,0);
        step(1,1,0,1,0,16'h6666,0,0,0);
        step(0,0,0,1,2'd1,16'h7777,1,0,0);
        step(0,0,0,0,2'd1,16'h0,0,0,2'd1);

        // Randomised segments with skewed rates
        for (int s = 0; s < 40; s++) begin
            int wr_pct, rd_pct, md;
            wr_pct = $urandom_range(10, 90);
            rd_pct = $urandom_range(10, 90);
            md     = $urandom_range(0, 2);
            for (int c = 0; c < 80; c++) begin
                bit fm, pk;
                fm = (md != 0); pk = (md == 2);
                if ($urandom_range(0, 199) == 0) begin fm = ~fm; end
                step(fm, pk, 1'($urandom), ($urandom_range(0,99) < wr_pct),
                     2'($urandom), 16'($urandom), ($urandom_range(0,99) < rd_pct/2),
                     ($urandom_range(0,99) < rd_pct/2), 2'($urandom));
            end
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                mismatched++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        end
    end
endmodule